// File: doc/BRIEF.md
# Next-Block Slot Annotation Buffer

This block holds the per-slot side information that special instructions in one eight-slot instruction block attach to the block that follows. There are two kinds of annotation. A predicate annotation carries a 3-bit selector for each slot, packed into a 24-bit immediate. A split annotation carries one bit per slot that tells the decoder to treat that 32-bit word as a pair of 16-bit register-to-register instructions.

The buffer keeps two copies of both annotations. The "pending" copy is written by the block now in flight. The "active" copy governs the block now being decoded. A block-advance pulse moves pending into active and empties pending. A flush empties both copies, so that a redirected fetch starts with clean slots. From the active copy, seven flag bits and a per-slot valid vector, the block computes an execute enable for each slot. It also computes an enable for each 16-bit half.

Top module: `slot_annot_buf`

## Requirements
- R1: After reset, both copies hold zero predicate codes and a zero split mask. `act_pred`, `act_split` and the upper-half enables are 0, and `exec_en` equals `slot_vld`.
- R2: A slot whose active predicate code is 000 is unpredicated: `exec_en[i]` equals `slot_vld[i]` for every value of `flags`.
- R3: Slot i's predicate code is `act_pred[3i+2:3i]`. When that code is k in 1..7, `exec_en[i]` equals `slot_vld[i] & flags[k-1]`. Here `flags[0]` is flag 1 and `flags[6]` is flag 7.
- R4: `half_en[2i]` equals `exec_en[i]`. `half_en[2i+1]` equals `exec_en[i]` when `act_split[i]` is 1 and is 0 otherwise, so one predicate code gates both halves of a split slot.
- R5: A write (`pred_wr` with `pred_imm`, or `split_wr` with `split_imm`) lands only in the pending copy. `act_pred`, `act_split`, `exec_en` and `half_en` do not change until a later advance.
- R6: On a clock edge with `blk_adv` high and `flush` low, the active copy takes the pending contents, and the result shows on the outputs after that edge. Unless a write comes in the same cycle, the pending copy becomes all zero.
- R7: A write in the same cycle as `blk_adv` belongs to the block that is starting. It goes into the new pending copy and reaches the active copy at the following advance.
- R8: `flush` clears both copies at the clock edge. It takes priority over `blk_adv` and over any write in the same cycle.
- R9: Predicate and split writes are independent. Either one, or both in the same cycle, updates only its own field of the pending copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear both copies (fetch redirect) |
| blk_adv | input | 1 | Block boundary: pending moves to active |
| pred_wr | input | 1 | Write predicate codes into pending copy |
| pred_imm | input | 24 | Eight 3-bit predicate codes, slot i at [3i+2:3i] |
| split_wr | input | 1 | Write split mask into pending copy |
| split_imm | input | 8 | Split mask, bit i for slot i |
| slot_vld | input | 8 | Slot holds a decoded instruction |
| flags | input | 7 | Flag bits, flags[k-1] is flag k |
| act_pred | output | 24 | Active predicate codes |
| act_split | output | 8 | Active split mask |
| exec_en | output | 8 | Per-slot execute enable |
| half_en | output | 16 | Per-half enable, [2i] low half, [2i+1] high half |

## Verification
The enables are combinational on `slot_vld`, `flags` and the active copy. The bench therefore checks them a short delay after driving new inputs in the low phase of the clock, while the active copy is still unchanged. Writes, advances and flushes take effect at exactly one clock edge. The bench updates its two-copy model at that edge and compares `act_pred` and `act_split` just after it. The enables are compared again in the next low phase. A write is checked as having no visible effect until an advance has passed through the pending copy.

// File: rtl/annot_pkg.sv
package annot_pkg;
  localparam int unsigned SLOTS_DEF  = 8;
  localparam int unsigned CODE_W_DEF = 3;
  localparam int unsigned FLAGS_DEF  = 7;

  // pick flag k (1-based) from a flag vector; code 0 or out of range -> 0
  function automatic logic flag_pick(input logic [7:0] code, input logic [31:0] fl,
                                     input int unsigned nflag);
    logic r;
    r = 1'b0;
    for (int unsigned k = 1; k <= 31; k++) begin
      if (k <= nflag && code == 8'(k)) r = fl[k-1];
    end
    return r;
  endfunction
endpackage

// File: rtl/annot_store.sv
module annot_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         adv,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] act,
  output logic [W-1:0] pend
);
  logic [W-1:0] act_d, pend_d;
  logic         upd;

  always_comb begin
    act_d  = act;
    pend_d = pend;
    if (flush) begin
      act_d  = '0;
      pend_d = '0;
    end else begin
      if (adv) begin
        act_d  = pend;
        pend_d = '0;
      end
      if (wr) pend_d = wdata;
    end
  end

  assign upd = flush | adv | wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= '0;
      pend <= '0;
    end else if (upd) begin
      act  <= act_d;
      pend <= pend_d;
    end
  end

  // R6: advance hands pending to active
  a_r6_adv_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !flush) |=> act == $past(pend));
  // R6: pending emptied by advance without write
  a_r6_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !flush && !wr) |=> pend == '0);
  // R8: flush empties both copies
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (act == '0 && pend == '0));
  // R5: active copy untouched without advance or flush
  a_r5_act_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !flush) |=> $stable(act));
  // R7: write lands in pending
  a_r7_wr_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !flush) |=> pend == $past(wdata));
endmodule

// File: rtl/slot_gate.sv
module slot_gate
  import annot_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned NFLAG  = FLAGS_DEF
) (
  input  logic [CODE_W-1:0] code,
  input  logic              vld,
  input  logic              split,
  input  logic [NFLAG-1:0]  flags,
  output logic              en,
  output logic              half_lo,
  output logic              half_hi
);
  logic flag_ok;

  always_comb begin
    flag_ok = flag_pick(8'(code), 32'(flags), NFLAG);
    en      = vld & ((code == '0) | flag_ok);
    half_lo = en;
    half_hi = en & split;
  end
endmodule

// File: rtl/slot_annot_buf.sv
module slot_annot_buf
  import annot_pkg::*;
#(
  parameter int unsigned SLOTS  = SLOTS_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned NFLAG  = FLAGS_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      blk_adv,
  input  logic                      pred_wr,
  input  logic [SLOTS*CODE_W-1:0]   pred_imm,
  input  logic                      split_wr,
  input  logic [SLOTS-1:0]          split_imm,
  input  logic [SLOTS-1:0]          slot_vld,
  input  logic [NFLAG-1:0]          flags,
  output logic [SLOTS*CODE_W-1:0]   act_pred,
  output logic [SLOTS-1:0]          act_split,
  output logic [SLOTS-1:0]          exec_en,
  output logic [2*SLOTS-1:0]        half_en
);
  localparam int unsigned PW = SLOTS * CODE_W;

  logic [PW-1:0]    pend_pred;
  logic [SLOTS-1:0] pend_split;

  annot_store #(.W(PW)) u_pred (
    .clk(clk), .rst_n(rst_n), .flush(flush), .adv(blk_adv),
    .wr(pred_wr), .wdata(pred_imm), .act(act_pred), .pend(pend_pred)
  );

  annot_store #(.W(SLOTS)) u_split (
    .clk(clk), .rst_n(rst_n), .flush(flush), .adv(blk_adv),
    .wr(split_wr), .wdata(split_imm), .act(act_split), .pend(pend_split)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    slot_gate #(.CODE_W(CODE_W), .NFLAG(NFLAG)) u_gate (
      .code   (act_pred[i*CODE_W +: CODE_W]),
      .vld    (slot_vld[i]),
      .split  (act_split[i]),
      .flags  (flags),
      .en     (exec_en[i]),
      .half_lo(half_en[2*i]),
      .half_hi(half_en[2*i+1])
    );

    // R2: unpredicated valid slot always enabled
    a_r2_unpred_en: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld[i] && act_pred[i*CODE_W +: CODE_W] == '0) |-> exec_en[i]);
    // R4: upper half only on split slots
    a_r4_hi_needs_split: assert property (@(posedge clk) disable iff (!rst_n)
      half_en[2*i+1] |-> (act_split[i] && exec_en[i]));
    // R3: no enable without a valid slot
    a_r3_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en[i] |-> slot_vld[i]);
  end

  // R9: a split write alone leaves predicate pending copy alone
  a_r9_indep: assert property (@(posedge clk) disable iff (!rst_n)
    (split_wr && !pred_wr && !blk_adv && !flush) |=> $stable(pend_pred));
endmodule

// File: tb/slot_annot_buf_test.sv
module slot_annot_buf_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, blk_adv, pred_wr, split_wr;
  logic [23:0] pred_imm;
  logic [7:0]  split_imm, slot_vld;
  logic [6:0]  flags;
  logic [23:0] act_pred;
  logic [7:0]  act_split, exec_en;
  logic [15:0] half_en;

  int total = 0;
  int bad   = 0;
  logic [23:0] m_act_p, m_pend_p;
  logic [7:0]  m_act_s, m_pend_s;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  slot_annot_buf uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .blk_adv(blk_adv),
    .pred_wr(pred_wr), .pred_imm(pred_imm), .split_wr(split_wr),
    .split_imm(split_imm), .slot_vld(slot_vld), .flags(flags),
    .act_pred(act_pred), .act_split(act_split), .exec_en(exec_en),
    .half_en(half_en)
  );

  function automatic logic [7:0] exp_en(input logic [23:0] p, input logic [7:0] v,
                                        input logic [6:0] f);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] c;
      c = p[3*i +: 3];
      r[i] = v[i] && (c == 3'd0 || f[c-3'd1]);
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_half(input logic [7:0] e, input logic [7:0] s);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i]   = e[i];
      r[2*i+1] = e[i] & s[i];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_comb(input string req);
    logic [7:0] e;
    e = exp_en(m_act_p, slot_vld, flags);
    chk(req, 32'(exec_en), 32'(e));
    chk(req, 32'(half_en), 32'(exp_half(e, m_act_s)));
  endtask

  // drive in low phase, check enables, clock, update model, check copies
  task automatic step(input logic fl, input logic ad, input logic pw, input logic [23:0] pi,
                      input logic sw, input logic [7:0] si, input logic [7:0] v,
                      input logic [6:0] f, input string req);
    flush = fl; blk_adv = ad; pred_wr = pw; pred_imm = pi;
    split_wr = sw; split_imm = si; slot_vld = v; flags = f;
    #1;
    chk_comb(req);
    @(posedge clk);
    if (fl) begin
      m_act_p = '0; m_pend_p = '0; m_act_s = '0; m_pend_s = '0;
    end else begin
      if (ad) begin
        m_act_p = m_pend_p; m_pend_p = '0;
        m_act_s = m_pend_s; m_pend_s = '0;
      end
      if (pw) m_pend_p = pi;
      if (sw) m_pend_s = si;
    end
    #1;
    chk(req, 32'(act_pred), 32'(m_act_p));
    chk(req, 32'(act_split), 32'(m_act_s));
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd4711;
    void'($urandom(seed));
    rst_n = 1'b0;
    flush = 0; blk_adv = 0; pred_wr = 0; split_wr = 0;
    pred_imm = '0; split_imm = '0; slot_vld = 8'hFF; flags = '0;
    m_act_p = '0; m_pend_p = '0; m_act_s = '0; m_pend_s = '0;
    #9;
    // R1: reset state
    chk("R1", 32'(act_pred), 0);
    chk("R1", 32'(act_split), 0);
    chk("R1", 32'(exec_en), 32'h00FF);
    chk("R1", 32'(half_en), 32'h5555);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R5: write into pending, active unchanged
    step(0, 0, 1, 24'o76543210, 1, 8'hA5, 8'hFF, 7'h00, "R5");
    step(0, 0, 0, '0, 0, '0, 8'hFF, 7'h00, "R5");
    // R6: advance moves pending to active
    step(0, 1, 0, '0, 0, '0, 8'hFF, 7'h00, "R6");
    // R3: each flag alone
    for (int k = 0; k < 7; k++) step(0, 0, 0, '0, 0, '0, 8'hFF, 7'(1 << k), "R3");
    // R4: all flags set, halves follow split mask
    step(0, 0, 0, '0, 0, '0, 8'hFF, 7'h7F, "R4");
    step(0, 0, 0, '0, 0, '0, 8'h3C, 7'h7F, "R4");
    // R6: next advance with empty pending clears active
    step(0, 1, 0, '0, 0, '0, 8'hFF, 7'h00, "R6");
    // R2: unpredicated ignores flags
    step(0, 0, 0, '0, 0, '0, 8'h96, 7'h55, "R2");
    // R7: write coincident with advance lands in new pending
    step(0, 0, 1, 24'o11111111, 0, '0, 8'hFF, 7'h01, "R7");
    step(0, 1, 1, 24'o22222222, 1, 8'h0F, 8'hFF, 7'h01, "R7");
    step(0, 0, 0, '0, 0, '0, 8'hFF, 7'h02, "R7");
    step(0, 1, 0, '0, 0, '0, 8'hFF, 7'h02, "R7");
    step(0, 0, 0, '0, 0, '0, 8'hFF, 7'h02, "R7");
    // R9: split-only write keeps pending predicates
    step(0, 0, 1, 24'o33333333, 0, '0, 8'hFF, 7'h04, "R9");
    step(0, 0, 0, '0, 1, 8'hF0, 8'hFF, 7'h04, "R9");
    step(0, 1, 0, '0, 0, '0, 8'hFF, 7'h04, "R9");
    step(0, 0, 0, '0, 0, '0, 8'hFF, 7'h04, "R9");
    // R8: flush beats advance and writes
    step(0, 0, 1, 24'o44444444, 1, 8'hFF, 8'hFF, 7'h00, "R8");
    step(1, 1, 1, 24'o55555555, 1, 8'hFF, 8'hFF, 7'h00, "R8");
    step(0, 1, 0, '0, 0, '0, 8'hFF, 7'h00, "R8");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic fl, ad, pw, sw;
      fl = ($urandom % 40) == 0;
      ad = ($urandom % 4) == 0;
      pw = ($urandom % 3) == 0;
      sw = ($urandom % 3) == 0;
      step(fl, ad, pw, 24'($urandom), sw, 8'($urandom), 8'($urandom),
           7'($urandom), "R3");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule